// File: doc/BRIEF.md
# Rank Multiplication Chip-Select Mapper

This block sits in the command path of a module-side memory buffer. A host controller can address only a limited number of ranks per channel, so each module shows the host half as many chip selects as it has physical ranks. A module with four physical ranks therefore looks like a dual-rank module. The block owns the back-end chip selects and decides which of the two physical ranks behind a host chip select each command reaches.

The choice is made when a bank is opened. On an activate, the most significant row-address bit picks the physical rank. That choice is recorded for the pair (host chip select, bank). Later column commands and single-bank precharges to that bank are steered by the record and not by their own address. Refresh, precharge-all and mode-register commands go to both physical ranks behind the selected host chip select.

The block also flags two protocol faults: more than one host chip select active in a cycle, and a column access to a bank that has no record. Every command, bank and address field leaves the block through one register stage.

Top module: `rank_mult_mapper`

## Requirements
- R1: All command strobes, the bank and the address leave the block exactly one clock after they arrive, unchanged. The back-end chip selects and both error flags share that one-clock delay.
- R2: Commands are decoded from {ras_n,cas_n,we_n} as follows: activate is 011, read is 101, write is 100, precharge is 010, refresh is 001 and mode-register is 000. With exactly one host chip select h low, an activate drives back-end chip select 2*h+m low and all others high, where m is the row-address MSB. It also records m for (h, bank).
- R3: With a record for (h, bank), a read or write drives back-end chip select 2*h+r low, where r is the recorded bit. The row-address MSB presented with the read or write is ignored.
- R4: A refresh, a mode-register command, or a precharge with address bit 10 high (precharge-all) drives both back-end chip selects 2*h and 2*h+1 low. A precharge-all also erases every record of host chip select h and no record of any other host chip select.
- R5: A precharge with address bit 10 low, to a bank that has a record, goes only to the recorded back-end chip select and erases that record. The same precharge to a bank with no record goes to both back-end chip selects behind h.
- R6: If two or more host chip selects are low in the same cycle, err_cs_conflict pulses high for one cycle, all back-end chip selects stay high, and no record changes.
- R7: A read or write to a (host chip select, bank) pair with no record pulses err_closed_bank high for one cycle and keeps all back-end chip selects high.
- R8: With every host chip select high, all back-end chip selects stay high and neither error flag is raised, whatever the strobes show.
- R9: While rst_n is low, all back-end chip selects are high, both flags are low, and all records are erased.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cs_n | input | HOST_CS | Host chip selects, active low |
| h_ras_n | input | 1 | Host row strobe |
| h_cas_n | input | 1 | Host column strobe |
| h_we_n | input | 1 | Host write-enable strobe |
| h_ba | input | log2(BANKS) | Host bank address |
| h_addr | input | ADDR_W | Host address |
| d_cs_n | output | 2*HOST_CS | Back-end chip selects, active low |
| d_ras_n | output | 1 | Registered row strobe |
| d_cas_n | output | 1 | Registered column strobe |
| d_we_n | output | 1 | Registered write-enable strobe |
| d_ba | output | log2(BANKS) | Registered bank address |
| d_addr | output | ADDR_W | Registered address |
| err_cs_conflict | output | 1 | More than one host chip select was low |
| err_closed_bank | output | 1 | Column access to a bank with no record |

## Verification
The bench sweeps every host chip select, every bank and both values of the rank bit. For each combination it issues an activate, then a read and a write whose row MSB is the opposite of the activate's. This shows whether steering follows the stored record or the live address. Each column access is followed by a single-bank precharge, a column access to the now-closed bank, and a second precharge. That sequence separates routed precharges from broadcast ones and shows that the record is erased.

Further patterns mix refresh, mode-register and precharge-all across both host chip selects, to show that erasure stays within one host chip select. Deliberate chip-select conflicts are followed by reads, which show that the table was left unchanged. A mid-run reset confirms that all records are lost.

// File: rtl/rmx_pkg.sv
package rmx_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_PREA,
      CMD_REF,
      CMD_OTHER
   } rmx_cmd_e;

   // Strobe decode; ap is the auto/all-precharge address bit
   function automatic rmx_cmd_e rmx_decode(input logic ras_n, input logic cas_n,
                                           input logic we_n, input logic ap);
      rmx_cmd_e c;
      case ({ras_n, cas_n, we_n})
         3'b111:  c = CMD_NOP;
         3'b011:  c = CMD_ACT;
         3'b101:  c = CMD_RD;
         3'b100:  c = CMD_WR;
         3'b010:  c = ap ? CMD_PREA : CMD_PRE;
         3'b001:  c = CMD_REF;
         default: c = CMD_OTHER;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/rmx_cs_select.sv
module rmx_cs_select #(
   parameter int HOST_CS = 2,
   localparam int HW     = $clog2(HOST_CS)
) (
   input  logic [HOST_CS-1:0] cs_n,
   output logic               any_sel,
   output logic               multi_sel,
   output logic [HW-1:0]      host
);

   always_comb begin
      host = '0;
      for (int i = 0; i < HOST_CS; i++) begin
         if (!cs_n[i]) host = HW'(i);
      end
   end

   assign any_sel   = |(~cs_n);
   assign multi_sel = ($countones(~cs_n) > 1);

endmodule

// File: rtl/rmx_rank_table.sv
module rmx_rank_table #(
   parameter int HOST_CS = 2,
   parameter int BANKS   = 8,
   localparam int HW     = $clog2(HOST_CS),
   localparam int BA_W   = $clog2(BANKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [HW-1:0]   host,
   input  logic [BA_W-1:0] bank,
   input  logic            set_en,
   input  logic            set_bit,
   input  logic            clr_one,
   input  logic            clr_all,
   output logic            rd_valid,
   output logic            rd_bit
);

   logic [BANKS-1:0] vld_q [HOST_CS];
   logic [BANKS-1:0] sel_q [HOST_CS];

   for (genvar g = 0; g < HOST_CS; g++) begin : g_host
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g] <= '0;
            sel_q[g] <= '0;
         end else if (host == HW'(g)) begin
            if (clr_all) begin
               vld_q[g] <= '0;
            end else if (clr_one) begin
               vld_q[g][bank] <= 1'b0;
            end else if (set_en) begin
               vld_q[g][bank] <= 1'b1;
               sel_q[g][bank] <= set_bit;
            end
         end
      end
   end

   assign rd_valid = vld_q[host][bank];
   assign rd_bit   = sel_q[host][bank];

endmodule

// File: rtl/rmx_cs_steer.sv
module rmx_cs_steer
   import rmx_pkg::*;
#(
   parameter int HOST_CS = 2,
   localparam int HW     = $clog2(HOST_CS),
   localparam int BE_CS  = 2 * HOST_CS
) (
   input  rmx_cmd_e         cmd,
   input  logic             any_sel,
   input  logic             multi_sel,
   input  logic [HW-1:0]    host,
   input  logic             row_bit,
   input  logic             rec_valid,
   input  logic             rec_bit,
   output logic [BE_CS-1:0] cs_n_nxt,
   output logic             e_conflict,
   output logic             e_closed,
   output logic             set_en,
   output logic             clr_one,
   output logic             clr_all
);

   logic [HW:0] pair_lo;
   logic [HW:0] pair_hi;

   assign pair_lo = {host, 1'b0};
   assign pair_hi = {host, 1'b1};

   always_comb begin
      cs_n_nxt   = '1;
      e_conflict = 1'b0;
      e_closed   = 1'b0;
      set_en     = 1'b0;
      clr_one    = 1'b0;
      clr_all    = 1'b0;
      if (multi_sel) begin
         e_conflict = 1'b1;
      end else if (any_sel) begin
         case (cmd)
            CMD_ACT: begin
               cs_n_nxt[{host, row_bit}] = 1'b0;
               set_en = 1'b1;
            end
            CMD_RD, CMD_WR: begin
               if (rec_valid) cs_n_nxt[{host, rec_bit}] = 1'b0;
               else           e_closed = 1'b1;
            end
            CMD_PRE: begin
               if (rec_valid) begin
                  cs_n_nxt[{host, rec_bit}] = 1'b0;
                  clr_one = 1'b1;
               end else begin
                  cs_n_nxt[pair_lo] = 1'b0;
                  cs_n_nxt[pair_hi] = 1'b0;
               end
            end
            CMD_PREA: begin
               cs_n_nxt[pair_lo] = 1'b0;
               cs_n_nxt[pair_hi] = 1'b0;
               clr_all = 1'b1;
            end
            default: begin
               cs_n_nxt[pair_lo] = 1'b0;
               cs_n_nxt[pair_hi] = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/rank_mult_mapper.sv
module rank_mult_mapper
   import rmx_pkg::*;
#(
   parameter int HOST_CS = 2,
   parameter int BANKS   = 8,
   parameter int ADDR_W  = 16,
   parameter int AP_BIT  = 10,
   localparam int HW     = $clog2(HOST_CS),
   localparam int BA_W   = $clog2(BANKS),
   localparam int BE_CS  = 2 * HOST_CS,
   localparam int ROW_MSB = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HOST_CS-1:0] h_cs_n,
   input  logic              h_ras_n,
   input  logic              h_cas_n,
   input  logic              h_we_n,
   input  logic [BA_W-1:0]   h_ba,
   input  logic [ADDR_W-1:0] h_addr,
   output logic [BE_CS-1:0]  d_cs_n,
   output logic              d_ras_n,
   output logic              d_cas_n,
   output logic              d_we_n,
   output logic [BA_W-1:0]   d_ba,
   output logic [ADDR_W-1:0] d_addr,
   output logic              err_cs_conflict,
   output logic              err_closed_bank
);

   // Elaboration-time parameter checks
   if (HOST_CS < 2 || (HOST_CS & (HOST_CS - 1)) != 0) begin : g_bad_host
      $error("HOST_CS must be a power of two, at least 2");
   end
   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (AP_BIT >= ROW_MSB) begin : g_bad_ap
      $error("AP_BIT must lie below the rank-select row bit");
   end

   rmx_cmd_e         cmd;
   logic             any_sel, multi_sel;
   logic [HW-1:0]    host;
   logic             rec_valid, rec_bit;
   logic [BE_CS-1:0] cs_n_nxt;
   logic             e_conflict, e_closed;
   logic             set_en, clr_one, clr_all;

   assign cmd = rmx_decode(h_ras_n, h_cas_n, h_we_n, h_addr[AP_BIT]);

   rmx_cs_select #(.HOST_CS(HOST_CS)) u_sel (
      .cs_n      (h_cs_n),
      .any_sel   (any_sel),
      .multi_sel (multi_sel),
      .host      (host)
   );

   rmx_rank_table #(.HOST_CS(HOST_CS), .BANKS(BANKS)) u_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .host     (host),
      .bank     (h_ba),
      .set_en   (set_en),
      .set_bit  (h_addr[ROW_MSB]),
      .clr_one  (clr_one),
      .clr_all  (clr_all),
      .rd_valid (rec_valid),
      .rd_bit   (rec_bit)
   );

   rmx_cs_steer #(.HOST_CS(HOST_CS)) u_steer (
      .cmd        (cmd),
      .any_sel    (any_sel),
      .multi_sel  (multi_sel),
      .host       (host),
      .row_bit    (h_addr[ROW_MSB]),
      .rec_valid  (rec_valid),
      .rec_bit    (rec_bit),
      .cs_n_nxt   (cs_n_nxt),
      .e_conflict (e_conflict),
      .e_closed   (e_closed),
      .set_en     (set_en),
      .clr_one    (clr_one),
      .clr_all    (clr_all)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_cs_n          <= '1;
         d_ras_n         <= 1'b1;
         d_cas_n         <= 1'b1;
         d_we_n          <= 1'b1;
         d_ba            <= '0;
         d_addr          <= '0;
         err_cs_conflict <= 1'b0;
         err_closed_bank <= 1'b0;
      end else begin
         d_cs_n          <= cs_n_nxt;
         d_ras_n         <= h_ras_n;
         d_cas_n         <= h_cas_n;
         d_we_n          <= h_we_n;
         d_ba            <= h_ba;
         d_addr          <= h_addr;
         err_cs_conflict <= e_conflict;
         err_closed_bank <= e_closed;
      end
   end

   // R1: fields pass through with one clock of delay
   a_r1_pass_delay: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (d_ba == $past(h_ba) && d_addr == $past(h_addr)
                 && d_ras_n == $past(h_ras_n) && d_we_n == $past(h_we_n)));

   // R2: an activate on a single host chip select opens exactly one back-end rank
   a_r2_act_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && cmd == CMD_ACT && $countones(~h_cs_n) == 1)
         |=> $countones(~d_cs_n) == 1);

   // R4: refresh reaches two back-end ranks
   a_r4_ref_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && cmd == CMD_REF && $countones(~h_cs_n) == 1)
         |=> $countones(~d_cs_n) == 2);

   // R6: a conflict drops the command
   a_r6_conflict_drop: assert property (@(posedge clk) disable iff (!rst_n)
      err_cs_conflict |-> &d_cs_n);

   // R7: a column access to a closed bank is dropped
   a_r7_closed_drop: assert property (@(posedge clk) disable iff (!rst_n)
      err_closed_bank |-> (&d_cs_n && !err_cs_conflict));

   // R8: deselect keeps the back end idle
   a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && &h_cs_n) |=> (&d_cs_n && !err_cs_conflict && !err_closed_bank));

endmodule

// File: tb/rank_mult_mapper_tb.sv
`timescale 1ns/1ps
module rank_mult_mapper_tb;

   localparam logic [2:0] ACT = 3'b011;
   localparam logic [2:0] RD  = 3'b101;
   localparam logic [2:0] WR  = 3'b100;
   localparam logic [2:0] PRE = 3'b010;
   localparam logic [2:0] REF = 3'b001;
   localparam logic [2:0] MRS = 3'b000;
   localparam logic [2:0] NOP = 3'b111;
   localparam logic [14:0] LOW_ROW = 15'h02B5; // bit 10 clear

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  h_cs_n = 2'b11;
   logic        h_ras_n = 1'b1, h_cas_n = 1'b1, h_we_n = 1'b1;
   logic [2:0]  h_ba = '0;
   logic [15:0] h_addr = '0;
   logic [3:0]  d_cs_n;
   logic        d_ras_n, d_cas_n, d_we_n;
   logic [2:0]  d_ba;
   logic [15:0] d_addr;
   logic        err_cs_conflict, err_closed_bank;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   rank_mult_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .h_cs_n(h_cs_n),
      .h_ras_n(h_ras_n), .h_cas_n(h_cas_n), .h_we_n(h_we_n),
      .h_ba(h_ba), .h_addr(h_addr), .d_cs_n(d_cs_n),
      .d_ras_n(d_ras_n), .d_cas_n(d_cas_n), .d_we_n(d_we_n),
      .d_ba(d_ba), .d_addr(d_addr),
      .err_cs_conflict(err_cs_conflict), .err_closed_bank(err_closed_bank)
   );

   function automatic logic [1:0] hsel(input int h);
      return ~(2'b01 << h);
   endfunction

   function automatic logic [3:0] one_low(input int idx);
      return ~(4'b0001 << idx);
   endfunction

   function automatic logic [3:0] pair_low(input int h);
      return ~(4'b0011 << (2 * h));
   endfunction

   // drive at a falling edge; the registered result is stable at the next one
   task automatic issue(input logic [1:0] cs, input logic [2:0] rcw,
                        input logic [2:0] ba, input logic [15:0] a);
      h_cs_n = cs;
      {h_ras_n, h_cas_n, h_we_n} = rcw;
      h_ba = ba;
      h_addr = a;
      @(negedge clk);
   endtask

   task automatic expect_out(input string req, input logic [3:0] ecs,
                             input logic econf, input logic eclosed);
      total++;
      if (d_cs_n !== ecs || err_cs_conflict !== econf || err_closed_bank !== eclosed) begin
         fails++;
         $display("FAIL %s: cs_n=%b conf=%b closed=%b, expected cs_n=%b conf=%b closed=%b",
                  req, d_cs_n, err_cs_conflict, err_closed_bank, ecs, econf, eclosed);
      end
   endtask

   task automatic expect_pass(input string req, input logic [2:0] rcw,
                              input logic [2:0] ba, input logic [15:0] a);
      total++;
      if ({d_ras_n, d_cas_n, d_we_n} !== rcw || d_ba !== ba || d_addr !== a) begin
         fails++;
         $display("FAIL %s: cmd=%b ba=%0d addr=%h, expected cmd=%b ba=%0d addr=%h",
                  req, {d_ras_n, d_cas_n, d_we_n}, d_ba, d_addr, rcw, ba, a);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      expect_out("R9 reset", 4'b1111, 1'b0, 1'b0);
      rst_n = 1'b1;
      issue(2'b11, RD, 3'd2, 16'h8000);
      expect_out("R8 deselect", 4'b1111, 1'b0, 1'b0);

      // sweep: host chip select x bank x rank bit
      for (int h = 0; h < 2; h++) begin
         for (int b = 0; b < 8; b++) begin
            for (int m = 0; m < 2; m++) begin
               issue(hsel(h), ACT, 3'(b), {1'(m), LOW_ROW});
               expect_out("R2 activate", one_low(2 * h + m), 1'b0, 1'b0);
               expect_pass("R1 passthrough", ACT, 3'(b), {1'(m), LOW_ROW});
               issue(hsel(h), RD, 3'(b), {1'(1 - m), LOW_ROW});
               expect_out("R3 read", one_low(2 * h + m), 1'b0, 1'b0);
               issue(hsel(h), WR, 3'(b), {1'(1 - m), LOW_ROW});
               expect_out("R3 write", one_low(2 * h + m), 1'b0, 1'b0);
               issue(hsel(h), PRE, 3'(b), {1'(1 - m), LOW_ROW});
               expect_out("R5 routed precharge", one_low(2 * h + m), 1'b0, 1'b0);
               issue(hsel(h), RD, 3'(b), {1'(m), LOW_ROW});
               expect_out("R7 closed read", 4'b1111, 1'b0, 1'b1);
               issue(hsel(h), PRE, 3'(b), {1'(m), LOW_ROW});
               expect_out("R5 unrecorded precharge", pair_low(h), 1'b0, 1'b0);
            end
         end
      end

      // broadcast commands and precharge-all scope
      issue(hsel(0), ACT, 3'd3, {1'b1, LOW_ROW});
      issue(hsel(1), ACT, 3'd3, {1'b0, LOW_ROW});
      issue(hsel(0), REF, 3'd0, 16'h0000);
      expect_out("R4 refresh", pair_low(0), 1'b0, 1'b0);
      issue(hsel(1), MRS, 3'd1, 16'h0123);
      expect_out("R4 mode register", pair_low(1), 1'b0, 1'b0);
      issue(hsel(0), PRE, 3'd0, 16'h0400);
      expect_out("R4 precharge-all", pair_low(0), 1'b0, 1'b0);
      issue(hsel(0), RD, 3'd3, {1'b1, LOW_ROW});
      expect_out("R4 records erased", 4'b1111, 1'b0, 1'b1);
      issue(hsel(1), RD, 3'd3, {1'b1, LOW_ROW});
      expect_out("R4 other host kept", one_low(2), 1'b0, 1'b0);

      // conflicts
      issue(2'b00, ACT, 3'd5, {1'b1, LOW_ROW});
      expect_out("R6 conflict", 4'b1111, 1'b1, 1'b0);
      issue(hsel(0), RD, 3'd5, {1'b1, LOW_ROW});
      expect_out("R6 no record made", 4'b1111, 1'b0, 1'b1);
      issue(hsel(1), ACT, 3'd5, {1'b0, LOW_ROW});
      issue(2'b00, ACT, 3'd5, {1'b1, LOW_ROW});
      expect_out("R6 conflict second", 4'b1111, 1'b1, 1'b0);
      issue(hsel(1), WR, 3'd5, {1'b1, LOW_ROW});
      expect_out("R6 record unchanged", one_low(2), 1'b0, 1'b0);
      issue(2'b11, ACT, 3'd5, 16'hFFFF);
      expect_out("R8 deselect activate", 4'b1111, 1'b0, 1'b0);
      expect_pass("R1 passthrough deselect", ACT, 3'd5, 16'hFFFF);
      issue(hsel(1), RD, 3'd5, {1'b1, LOW_ROW});
      expect_out("R8 record untouched", one_low(2), 1'b0, 1'b0);

      // reset erases records
      rst_n = 1'b0;
      issue(2'b11, NOP, 3'd0, 16'h0000);
      expect_out("R9 reset mid-run", 4'b1111, 1'b0, 1'b0);
      rst_n = 1'b1;
      issue(hsel(1), RD, 3'd5, {1'b0, LOW_ROW});
      expect_out("R9 records cleared", 4'b1111, 1'b0, 1'b1);
      issue(2'b11, NOP, 3'd0, 16'h0000);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule